// File: doc/BRIEF.md
# I2C Register-Bank Slave

This block is the slave end of a two-wire serial bus. It lets a bus master read and write a small bank of 8-bit control registers. The system clock samples SCL and SDA, and it must run at least ten times faster than SCL. The slave never drives SDA high. It only enables an open-drain pull-down, `sda_oe_o`, where 1 pulls the line low. The block finds START and STOP conditions on the synchronized lines. It compares the first byte of each transfer with its device address, then serves a write or a read.

A write carries a register pointer, then any number of data bytes, each stored at the pointer, which then steps forward, until a STOP. A read returns bytes from the current pointer. The usual pattern is a write of the pointer, then a repeated START and a read. The register contents leave the block on a flat parallel bus. Each stored byte also raises a one-cycle strobe with its index and data.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `wr_stb_o` is 0 and all 16 registers read 0x00 on `regs_o` (register k in bits 8k+7..8k).
- R2: `sda_oe_o` changes only while SCL is low. START (SDA falling, SCL high) and STOP (SDA rising, SCL high) are the only SDA changes the block treats as control.
- R3: The first byte after a START is the address byte, sent MSB first. Its upper seven bits must equal binary 110000 followed by `addr_strap_i`, and its LSB is R/W (0 = write). This gives 0xC0/0xC1 with the strap low and 0xC2/0xC3 with it high. On a match the slave holds SDA low through the ninth clock.
- R4: On an address mismatch the slave does not acknowledge. Until the next START it drives nothing and writes nothing, even if a matching byte is clocked later.
- R5: In a write, the byte after the address loads the pointer and is acknowledged. Each later byte is acknowledged and stored at the pointer, and the pointer then steps. This repeats for any number of bytes until a STOP.
- R6: The pointer steps by one. It goes from 15 to 0, and values from 16 upward count modulo 256.
- R7: A data byte written while the pointer is 16 or more is still acknowledged. It is discarded: no strobe is raised and no register changes.
- R8: Each stored byte raises `wr_stb_o` for exactly one cycle, with `wr_idx_o` and `wr_data_o`. The named register shows the data on the next cycle. Registers change at no other time.
- R9: In a read, the slave shifts out the register at the pointer, MSB first, and the pointer steps after each byte. A pointer of 16 or more reads as 0xFF.
- R10: A master not-acknowledge on the ninth clock of a read byte ends the read. The slave releases SDA and drives nothing until the next START.
- R11: A START in the middle of a transfer (a repeated START) drops any partial byte and returns the slave to address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 10x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| addr_strap_i | input | 1 | Device address LSB strap |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| regs_o | output | 128 | Flat register contents, register k at bits 8k+7..8k |
| wr_stb_o | output | 1 | One-cycle strobe per stored byte |
| wr_idx_o | output | 4 | Register index of the stored byte |
| wr_data_o | output | 8 | Value of the stored byte |

## Verification
The bench uses a wired-AND bus model. It mixes random register writes and pointer-then-read transfers, with strap changes, against a reference register model.

Directed cases cover:
- Pointer wrap from 15 to 0, which a design with a plain 4-bit pointer would miss only for out-of-range bases.
- Writes beyond the bank, which a careless design would alias onto a low register.
- An address byte meant for the other strap value followed by a byte that would match. A slave that resumed matching without a START would acknowledge it.
- A repeated START four bits into a data byte. A slave that kept its bit count would misframe the next address.
- A master not-acknowledge followed by more clocks. A slave that kept shifting would pull SDA low.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } i2c_st_e;

  // pointer step: last register wraps to 0, out-of-range values count mod 256
  function automatic logic [7:0] ptr_step(input logic [7:0] p, input int nreg);
    return (int'(p) == nreg - 1) ? 8'd0 : p + 8'd1;
  endfunction

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int NLINES = 2,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] d_i,
  output logic [NLINES-1:0] q_o,
  output logic [NLINES-1:0] prev_o
);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '1;
        prev_q <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
        prev_q <= pipe_q[STAGES-1];
      end
    end

    assign q_o[g]    = pipe_q[STAGES-1];
    assign prev_o[g] = prev_q;
  end

endmodule

// File: rtl/i2c_rb_bank.sv
module i2c_rb_bank #(
  parameter int NREG = 16,
  parameter int IW   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     widx_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        rptr_i,
  output logic [7:0]        rdata_o,
  output logic [NREG*8-1:0] regs_o
);

  logic [7:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  // out-of-range reads return the released-bus value
  assign rdata_o = (int'(rptr_i) < NREG) ? mem_q[rptr_i[IW-1:0]] : 8'hFF;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = mem_q[g];
  end

endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
  import i2c_rb_pkg::*;
#(
  parameter int         NREG   = 16,
  parameter int         IW     = 4,
  parameter logic [5:0] PREFIX = 6'b110000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_q_i,
  input  logic          scl_p_i,
  input  logic          sda_q_i,
  input  logic          sda_p_i,
  input  logic          strap_i,
  input  logic [7:0]    rdata_i,
  output logic [7:0]    rptr_o,
  output logic          sda_oe_o,
  output logic          wr_stb_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [7:0]    wr_data_o
);

  logic start_c, stop_c, scl_rise, scl_fall;
  assign start_c  = scl_q_i & scl_p_i & sda_p_i & ~sda_q_i;
  assign stop_c   = scl_q_i & scl_p_i & ~sda_p_i & sda_q_i;
  assign scl_rise = scl_q_i & ~scl_p_i;
  assign scl_fall = ~scl_q_i & scl_p_i;

  i2c_st_e       st_q;
  logic [3:0]    cnt_q;  // SCL rises seen in current byte, 0..9
  logic [7:0]    sh_q, tx_q, ptr_q, wd_q;
  logic          rw_q, nack_q, oe_q, stb_q;
  logic [IW-1:0] idx_q;

  logic in_range, addr_hit, active;
  assign in_range = int'(ptr_q) < NREG;
  assign addr_hit = sh_q[7:1] == {PREFIX, strap_i};
  assign active   = st_q inside {ST_ADDR, ST_PTR, ST_WDATA, ST_RDATA};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      wd_q   <= '0;
      rw_q   <= 1'b0;
      nack_q <= 1'b0;
      oe_q   <= 1'b0;
      stb_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      stb_q <= 1'b0;
      if (start_c) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_c) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (cnt_q < 4'd8) sh_q <= {sh_q[6:0], sda_q_i};
          else              nack_q <= sda_q_i;
          if (cnt_q < 4'd9) cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall) begin
          if (cnt_q == 4'd8) begin
            // acknowledge slot begins
            case (st_q)
              ST_ADDR: begin
                if (addr_hit) begin
                  oe_q <= 1'b1;
                  rw_q <= sh_q[0];
                end else begin
                  oe_q <= 1'b0;
                  st_q <= ST_SKIP;
                end
              end
              ST_PTR: begin
                oe_q  <= 1'b1;
                ptr_q <= sh_q;
              end
              ST_WDATA: begin
                oe_q <= 1'b1;
                if (in_range) begin
                  stb_q <= 1'b1;
                  idx_q <= ptr_q[IW-1:0];
                  wd_q  <= sh_q;
                end
                ptr_q <= ptr_step(ptr_q, NREG);
              end
              ST_RDATA: begin
                oe_q  <= 1'b0;
                ptr_q <= ptr_step(ptr_q, NREG);
              end
              default: oe_q <= 1'b0;
            endcase
          end else if (cnt_q == 4'd9) begin
            // acknowledge slot ends
            cnt_q <= '0;
            case (st_q)
              ST_ADDR: begin
                if (rw_q) begin
                  st_q <= ST_RDATA;
                  tx_q <= rdata_i;
                  oe_q <= ~rdata_i[7];
                end else begin
                  st_q <= ST_PTR;
                  oe_q <= 1'b0;
                end
              end
              ST_PTR: begin
                st_q <= ST_WDATA;
                oe_q <= 1'b0;
              end
              ST_RDATA: begin
                if (nack_q) begin
                  st_q <= ST_SKIP;
                  oe_q <= 1'b0;
                end else begin
                  tx_q <= rdata_i;
                  oe_q <= ~rdata_i[7];
                end
              end
              default: oe_q <= 1'b0;
            endcase
          end else if (st_q == ST_RDATA && cnt_q != 4'd0) begin
            oe_q <= ~tx_q[3'd7 - cnt_q[2:0]];
          end
        end
      end
    end
  end

  assign rptr_o    = ptr_q;
  assign sda_oe_o  = oe_q;
  assign wr_stb_o  = stb_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = wd_q;

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         NREG   = 16,
  parameter logic [5:0] PREFIX = 6'b110000,
  parameter int         SYNC   = 2,
  localparam int        IW     = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o,
  output logic              wr_stb_o,
  output logic [IW-1:0]     wr_idx_o,
  output logic [7:0]        wr_data_o
);

  logic [1:0] ln_q, ln_p;
  logic       scl_q, sda_q;
  logic [7:0] rptr, rdata;

  i2c_rb_sync #(.NLINES(2), .STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (ln_q),
    .prev_o (ln_p)
  );

  assign scl_q = ln_q[1];
  assign sda_q = ln_q[0];

  i2c_rb_fsm #(.NREG(NREG), .IW(IW), .PREFIX(PREFIX)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_q_i   (scl_q),
    .scl_p_i   (ln_p[1]),
    .sda_q_i   (sda_q),
    .sda_p_i   (ln_p[0]),
    .strap_i   (addr_strap_i),
    .rdata_i   (rdata),
    .rptr_o    (rptr),
    .sda_oe_o  (sda_oe_o),
    .wr_stb_o  (wr_stb_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o)
  );

  i2c_rb_bank #(.NREG(NREG), .IW(IW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_stb_o),
    .widx_i  (wr_idx_o),
    .wdata_i (wr_data_o),
    .rptr_i  (rptr),
    .rdata_o (rdata),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker #(
  parameter int NREG = 16,
  parameter int IW   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_q,
  input logic              sda_oe_o,
  input logic              wr_stb_o,
  input logic [IW-1:0]     wr_idx_o,
  input logic [7:0]        wr_data_o,
  input logic [NREG*8-1:0] regs_o
);

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_q); // R2

  AST_STB_IN_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> !scl_q); // R5

  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R8

  AST_REG_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> regs_o[int'($past(wr_idx_o))*8 +: 8] == $past(wr_data_o)); // R8

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_o |=> $stable(regs_o)); // R8

endmodule

bind i2c_regbank_slave i2c_rb_checker #(.NREG(NREG), .IW(IW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_q     (scl_q),
  .sda_oe_o  (sda_oe_o),
  .wr_stb_o  (wr_stb_o),
  .wr_idx_o  (wr_idx_o),
  .wr_data_o (wr_data_o),
  .regs_o    (regs_o)
);

// File: tb/test_i2c_regbank_slave.sv
`timescale 1ns/1ps
module test_i2c_regbank_slave;

  localparam int H = 12;  // SCL half period in system clocks

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic         sda_bus, sda_oe;
  logic [127:0] regs;
  logic         stb;
  logic [3:0]   idx;
  logic [7:0]   wdat;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_regbank_slave i_i2c_regbank_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs),
    .wr_stb_o(stb), .wr_idx_o(idx), .wr_data_o(wdat)
  );

  int total = 0, bad = 0;
  int exp_stb = 0, seen_stb = 0;
  logic [7:0] m_regs [16];
  logic [7:0] buf_q [8];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p == 8'd15) ? 8'd0 : p + 8'd1;
  endfunction

  // monitors: strobe commit (R8) and drive timing (R2)
  logic       pend = 0, last_oe = 0;
  logic [3:0] pidx;
  logic [7:0] pdat;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) chk(regs[int'(pidx)*8 +: 8] == pdat, "R8 commit", regs[int'(pidx)*8 +: 8], pdat);
      pend = stb;
      if (stb) begin
        seen_stb++;
        pidx = idx;
        pdat = wdat;
      end
      if (sda_oe != last_oe) chk(scl_m == 1'b0, "R2 oe while scl high", 1, 0);
      last_oe = sda_oe;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic i2c_start();
    sda_m = 1; scl_m = 1; tick(H);
    sda_m = 0; tick(H);
    scl_m = 0; tick(2);
  endtask

  task automatic i2c_rstart();
    sda_m = 1; tick(H);
    scl_m = 1; tick(H);
    sda_m = 0; tick(H);
    scl_m = 0; tick(2);
  endtask

  task automatic i2c_stop();
    sda_m = 0; tick(H);
    scl_m = 1; tick(H);
    sda_m = 1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(H);
    scl_m = 1; tick(H);
    scl_m = 0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; tick(H);
    scl_m = 1; tick(H/2);
    ack = !sda_bus;
    tick(H/2);
    scl_m = 0; tick(2);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_m = 1; tick(H/2);
      b[i] = sda_bus;
      tick(H/2);
      scl_m = 0; tick(2);
    end
    sda_m = nack; tick(H);
    scl_m = 1; tick(H);
    scl_m = 0; tick(2);
    sda_m = 1;
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {6'b110000, strap, rd};
  endfunction

  task automatic chk_regs(input string req);
    bit ok = 1;
    int first = -1;
    for (int i = 0; i < 16; i++)
      if (regs[i*8 +: 8] !== m_regs[i]) begin
        ok = 0;
        if (first < 0) first = i;
      end
    if (first < 0) first = 0;
    chk(ok, req, regs[first*8 +: 8], m_regs[first]);
    chk(seen_stb == exp_stb, {req, " strobe count"}, seen_stb, exp_stb);
  endtask

  // write n bytes from buf_q starting at pointer p
  task automatic m_write(input logic [7:0] p, input int n, input string req);
    bit ack;
    logic [7:0] ptr = p;
    i2c_start();
    send_byte(dev(0), ack); chk(ack, "R3 write address ack", ack, 1);
    send_byte(p, ack);      chk(ack, "R5 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(buf_q[i], ack);
      chk(ack, {req, " data ack"}, ack, 1);
      if (ptr < 8'd16) begin
        m_regs[ptr[3:0]] = buf_q[i];
        exp_stb++;
      end
      ptr = nxt(ptr);
    end
    i2c_stop();
    chk_regs(req);
  endtask

  // set pointer, repeated START, read n bytes (R9, R11)
  task automatic m_read(input logic [7:0] p, input int n);
    bit ack;
    logic [7:0] ptr = p, got, exp;
    i2c_start();
    send_byte(dev(0), ack); chk(ack, "R3 write address ack", ack, 1);
    send_byte(p, ack);      chk(ack, "R5 pointer ack", ack, 1);
    i2c_rstart();
    send_byte(dev(1), ack); chk(ack, "R11 read address after repeated start", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, got);
      exp = (ptr < 8'd16) ? m_regs[ptr[3:0]] : 8'hFF;
      chk(got == exp, "R9 read data", got, exp);
      ptr = nxt(ptr);
    end
    tick(6);
    chk(sda_oe == 1'b0, "R10 released after nack", sda_oe, 0);
    recv_byte(1, got);
    chk(got == 8'hFF, "R10 no drive after nack", got, 8'hFF);
    i2c_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] got;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
    tick(5);
    rst_n = 1;
    @(negedge clk);
    chk(sda_oe == 1'b0, "R1 oe reset", sda_oe, 0);
    chk(stb == 1'b0, "R1 strobe reset", stb, 0);
    chk(regs == '0, "R1 regs reset", regs[31:0], 0);
    tick(4);

    // R5 basic burst
    for (int i = 0; i < 8; i++) buf_q[i] = 8'(8'h11 * (i + 1));
    m_write(8'd2, 5, "R5 burst");
    m_read(8'd2, 5);

    // R6 wrap 14,15,0,1
    for (int i = 0; i < 8; i++) buf_q[i] = 8'(8'hA0 + i);
    m_write(8'd14, 4, "R6 wrap");
    m_read(8'd15, 3);

    // R7 out of range discarded, and 255 steps to 0
    for (int i = 0; i < 8; i++) buf_q[i] = 8'(8'h5A ^ i);
    m_write(8'd32, 2, "R7 discard");
    m_write(8'd255, 2, "R7 ptr 255 step");
    m_read(8'd40, 2);

    // R3 strap high
    strap = 1;
    for (int i = 0; i < 8; i++) buf_q[i] = 8'(8'h3C + i);
    m_write(8'd7, 2, "R3 strap high");

    // R4 mismatch: address for other strap, then a would-be match without START
    strap = 0;
    i2c_start();
    send_byte(8'hC2, ack); chk(!ack, "R4 mismatch nack", ack, 0);
    send_byte(8'hC0, ack); chk(!ack, "R4 ignored until start", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R4 ignored byte", ack, 0);
    i2c_stop();
    chk_regs("R4 no write");

    // R11 repeated START inside a data byte
    i2c_start();
    send_byte(dev(0), ack);
    send_byte(8'd3, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_rstart();
    send_byte(dev(0), ack); chk(ack, "R11 address after mid-byte start", ack, 1);
    send_byte(8'd5, ack);
    send_byte(8'hAB, ack);
    m_regs[5] = 8'hAB; exp_stb++;
    i2c_stop();
    chk_regs("R11 mid-byte restart");

    // random mix
    for (int t = 0; t < 24; t++) begin
      logic [7:0] p;
      int n;
      strap = 1'($urandom % 2);
      p = ($urandom % 6 == 0) ? 8'(16 + $urandom % 240) : 8'($urandom % 16);
      n = 1 + int'($urandom % 5);
      if ($urandom % 2 == 0) begin
        for (int i = 0; i < 8; i++) buf_q[i] = 8'($urandom);
        m_write(p, n, "R5 random write");
      end else begin
        m_read(p, n);
      end
    end

    // R9 read of whole bank
    m_read(8'd0, 16);
    got = 8'h00;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule